// File: doc/BRIEF.md
# GPIO interrupt summary aggregator

The block gathers the pending flags raised by a bank of GPIO pin cells into a compact 64-bit summary. Each summary bit stands for one group of four neighbouring pins. A single level interrupt line to the host is driven from that summary. The host reads the summary as two 32-bit words to find which groups need service, then clears the flags in the pin cells. It then writes an end-of-interrupt bit in a master register, which re-arms the line.

No separate acknowledge is needed before the handler runs. The line stays high from the moment it is raised until the end-of-interrupt write. It then drops for exactly one cycle and comes back only if some group is still pending. A master enable bit in the same register gates the line and resets to disabled.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is the OR of the pending inputs of pins 4n, 4n+1, 4n+2 and 4n+3, for n from 0 to 45 (184 pins).
- R2: A read at address 0 returns summary bits 31..0. A read at address 1 returns summary bits 63..32, with summary bit 32 in data bit 0.
- R3: Summary bits 46 to 63 always read as zero, so data bits 31..14 at address 1 are zero.
- R4: The summary is a combinational view of the pending inputs. When a pending input is cleared, the readback changes in the same cycle, with no clock edge needed.
- R5: The master register is at address 2. Bit 0 is the interrupt enable; it resets to 0 and reads back the value last written.
- R6: Bit 1 of a write to the master register is the end-of-interrupt strobe. It acts only in the write cycle and always reads back as 0.
- R7: With the enable set and any summary bit set, irq_o rises after the next clock edge. It then stays high until an end-of-interrupt write, even if every pending input clears.
- R8: After the clock edge that accepts an end-of-interrupt write, irq_o is low for exactly one cycle. If any summary bit is set and the enable is set at the following edge, it rises again; otherwise it stays low.
- R9: While the enable bit is 0, irq_o is low whatever the pending inputs are.
- R10: Writes to addresses 0, 1 and 3 have no effect on any state. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | 184 | Per-pin pending flags from the pin cells |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational register read data |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume that the pending inputs and the register strobes change only between clock edges and are stable at each edge. They also assume that the pin cells, not this block, clear a pending flag. The bench drives every input on the falling edge and reads the combinational data a short delay after driving the address. It clears pending flags directly to stand in for the pin cells. The end-of-interrupt sequences include both cases: a group that is still pending at the write, and one whose flag was dropped before it.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SUM_W  = 2 * WORD_W;
  localparam logic [1:0] ADDR_SUM_LO = 2'd0;
  localparam logic [1:0] ADDR_SUM_HI = 2'd1;
  localparam logic [1:0] ADDR_MASTER = 2'd2;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_EOI = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } irq_state_e;
endpackage

// File: rtl/gis_summary.sv
module gis_summary
  import gis_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 184,
  parameter int unsigned GROUP_SZ  = 4,
  localparam int unsigned NUM_SUM  = (NUM_PINS + GROUP_SZ - 1) / GROUP_SZ,
  localparam int unsigned PAD_PINS = NUM_SUM * GROUP_SZ
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [SUM_W-1:0]    sum_o,
  output logic                any_o
);
  logic [PAD_PINS-1:0] pend_pad;
  logic [NUM_SUM-1:0]  grp;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_PINS-1:0] = pend_i;
  end

  for (genvar g = 0; g < NUM_SUM; g++) begin : g_grp
    assign grp[g] = |pend_pad[g*GROUP_SZ +: GROUP_SZ];
  end

  always_comb begin
    sum_o = '0;
    sum_o[NUM_SUM-1:0] = grp;
  end

  assign any_o = |grp;
endmodule

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [SUM_W-1:0]  sum_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              en_o,
  output logic              eoi_o
);
  logic en_q;
  logic wr_master;

  assign wr_master = we_i && (addr_i == ADDR_MASTER);
  assign eoi_o     = wr_master && wdata_i[BIT_EOI];
  assign en_o      = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (wr_master) en_q <= wdata_i[BIT_EN];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SUM_LO: rdata_o = sum_i[WORD_W-1:0];
      ADDR_SUM_HI: rdata_o = sum_i[SUM_W-1:WORD_W];
      ADDR_MASTER: rdata_o[BIT_EN] = en_q;
      default:     rdata_o = '0;
    endcase
  end

  assert_en_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_master |=> (en_q == $past(wdata_i[BIT_EN])));

  assert_eoi_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_MASTER) |-> (rdata_o[BIT_EOI] == 1'b0));
endmodule

// File: rtl/gis_irq_ctrl.sv
module gis_irq_ctrl
  import gis_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic en_i,
  input  logic eoi_i,
  output logic irq_o
);
  irq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (en_i && any_i) state_d = ST_ACTIVE;
      ST_ACTIVE: if (eoi_i) state_d = ST_GAP;
      ST_GAP:    state_d = (en_i && any_i) ? ST_ACTIVE : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign irq_o = (state_q == ST_ACTIVE) && en_i;

  assert_hold_until_eoi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> (irq_o || $past(eoi_i) || !en_i));

  assert_eoi_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && eoi_i) |=> !irq_o);

  assert_raise_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $past(state_q != ST_ACTIVE)) |-> $past(any_i && en_i));
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gis_pkg::*;
#(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GROUP_SZ = 4,
  localparam int unsigned NUM_SUM = (NUM_PINS + GROUP_SZ - 1) / GROUP_SZ,
  localparam logic [SUM_W-1:0] VALID_MASK = (SUM_W'(1) << NUM_SUM) - SUM_W'(1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  logic [SUM_W-1:0] sum;
  logic any, en, eoi;

  gis_summary #(.NUM_PINS(NUM_PINS), .GROUP_SZ(GROUP_SZ)) u_sum (
    .pend_i(pend_i), .sum_o(sum), .any_o(any)
  );

  gis_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .sum_i(sum), .rdata_o(reg_rdata_o),
    .en_o(en), .eoi_o(eoi)
  );

  gis_irq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_i(any), .en_i(en), .eoi_i(eoi),
    .irq_o(irq_o)
  );

  assert_hi_pad_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_SUM_HI) |->
      ((reg_rdata_o & ~VALID_MASK[SUM_W-1:WORD_W]) == '0));

  assert_no_irq_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_MASTER && !reg_wdata_i[BIT_EN]) |=> !irq_o);
endmodule

// File: tb/gpio_irq_summary_test.sv
module gpio_irq_summary_test;
  localparam int NP = 184;
  logic clk = 0, rst_ni = 0;
  logic [NP-1:0] pend = '0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_summary uut (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [63:0] exp_sum(input logic [NP-1:0] p);
    logic [63:0] r = '0;
    for (int i = 0; i < 46; i++) r[i] = |p[4*i +: 4];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic chk_sum(input string req);
    logic [63:0] e;
    logic [31:0] d;
    e = exp_sum(pend);
    rd(2'd0, d); chk(req, d, e[31:0]);
    rd(2'd1, d); chk(req, d, e[63:32]);
  endtask

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R9 reset irq", {31'd0, irq}, 0);
    rd(2'd2, d); chk("R5 reset master", d, 0);
    rd(2'd3, d); chk("R10 addr3", d, 0);

    // R1 R2 R3 one-hot sweep over every pin
    for (int p = 0; p < NP; p++) begin
      pend = '0; pend[p] = 1'b1; #0.5;
      chk_sum("R1/R2 onehot");
    end
    pend = '1; #0.5; chk_sum("R3 all ones");
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < NP; i++) pend[i] = ((i * 7 + k * 13) % 11) == 0;
      #0.5; chk_sum("R1 pattern");
    end
    // R4 drop is visible without a clock edge
    pend = '0; pend[130] = 1; #0.5;
    rd(2'd1, d); chk("R4 set", d, 32'h1 << 0);
    pend[130] = 0; #0.5;
    rd(2'd1, d); chk("R4 drop", d, 0);

    // R9 disabled with pending
    @(negedge clk); pend = '0; pend[5] = 1;
    repeat (3) @(negedge clk);
    chk("R9 disabled", {31'd0, irq}, 0);

    wr(2'd2, 32'h1);
    rd(2'd2, d); chk("R5 en readback", d, 1);
    @(negedge clk);
    chk("R7 raise", {31'd0, irq}, 1);
    pend = '0;
    @(negedge clk);
    chk("R7 hold after clear", {31'd0, irq}, 1);

    wr(2'd2, 32'h3);
    chk("R8 gap", {31'd0, irq}, 0);
    rd(2'd2, d); chk("R6 eoi reads zero", d, 1);
    @(negedge clk);
    chk("R8 stays low", {31'd0, irq}, 0);

    pend[100] = 1;
    @(negedge clk);
    chk("R7 re-raise", {31'd0, irq}, 1);
    wr(2'd2, 32'h3);
    chk("R8 gap pending", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R8 reassert", {31'd0, irq}, 1);

    wr(2'd2, 32'h0);
    chk("R9 disable", {31'd0, irq}, 0);

    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R10 master untouched", d, 0);
    chk_sum("R10 summary untouched");
    chk("R10 irq", {31'd0, irq}, 0);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R10 state kept", {31'd0, irq}, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule